// File: doc/BRIEF.md
# UART Channel Register and Command Controller

This block is the software-facing control layer of one UART channel. It decodes byte-wide accesses inside a 64-byte window into a pair of mode registers, a status view, an interrupt status view with its mask, two read-only baud divider bytes, a command port and the data port. The serializer, the baud generator and the receive FIFO sit outside it. Transmit bytes leave through a valid/ready byte handoff. The receive FIFO reports its head byte and its empty and full flags, and it takes a pop strobe, a flush strobe and an enable.

The command byte holds three independent sub-commands: a miscellaneous action, a transmitter action and a receiver action. They are applied in that order, so a later field can undo an earlier one in the same byte. The two mode registers share one offset. A pointer selects between them and moves to the second register after every write. A level interrupt combines four interrupt sources with a mask. The source for the receive interrupt is set by a bit in the first mode register.

Each bus access lasts one cycle, marked by `bus_req`. Read data and the receive pop strobe are combinational within that cycle. Writes take effect at the next clock edge.

Top module: `uart_regctl`

## Requirements
- R1: After reset, the status reads 0x08 while the FIFO reports empty. Both mode registers, the interrupt status and the mask read 0. `irq` and `tx_valid` are low, and `rx_enable` is low.
- R2: Offsets are decoded as follows: 0x00 mode, 0x04 status (read), 0x08 command (write), 0x0C data, 0x14 interrupt status (read) and mask (write), 0x18 and 0x1C baud divider bytes (read, given by parameters). Every other read returns 0. Writes to offsets other than 0x00, 0x08, 0x0C and 0x14 change nothing.
- R3: Offset 0x00 reaches mode register 1 when the pointer is 0 and mode register 2 when it is 1. A write stores into the selected register and then sets the pointer to 1. Misc command 1 clears the pointer. Reads do not move it.
- R4: The status byte is laid out as follows: bit0 = FIFO not empty, bit1 = FIFO full, bit2 = transmitter enabled, bit3 = no byte pending for transmit. Bits 7:4 read 0.
- R5: The command byte is decoded as three fields. Bits 6:4 are misc (1 pointer reset, 2 receiver reset, 3 transmitter reset, 5 clear delta-break; the other values do nothing). Bits 3:2 are transmit (1 enable, 2 disable). Bits 1:0 are receive (1 enable, 2 disable). The value 3 in a 2-bit field is ignored. The fields apply misc, then transmit, then receive.
- R6: A receiver reset pulses `rx_flush` for the cycle of the command write and disables the receiver.
- R7: A transmitter reset disables the transmitter and discards any pending byte, so status bit3 is set and a later enable sends nothing.
- R8: A data write stores a byte and marks it pending, which clears status bit3. `tx_valid` is high while the transmitter is enabled and a byte is pending. The byte clears on the edge where `tx_valid` and `tx_ready` are both high. While stalled, `tx_data` holds. A data write on the edge of a handshake leaves the new byte pending.
- R9: The interrupt status is laid out as follows: bit0 = transmitter enabled. Bit1 = FIFO full when mode register 1 bit6 is 1, otherwise FIFO not empty. Bit2 = delta-break latch, which is set by a `brk_evt` pulse, cleared by misc command 5, and set wins if both occur together. All other bits read 0.
- R10: `irq` is high exactly when (interrupt status AND mask) is nonzero. The mask is written at offset 0x14.
- R11: A read of 0x0C while the FIFO is not empty returns `rx_head` and pulses `rx_pop` in that cycle. When the FIFO is empty, the read returns 0 with no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | One-cycle access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset in window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during the read cycle |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Serializer accepts byte |
| tx_data | output | 8 | Transmit byte |
| rx_head | input | 8 | FIFO head byte |
| rx_empty | input | 1 | FIFO empty flag |
| rx_full | input | 1 | FIFO full flag |
| rx_pop | output | 1 | Pop FIFO head |
| rx_flush | output | 1 | Flush FIFO |
| rx_enable | output | 1 | Receiver enabled |
| brk_evt | input | 1 | One-cycle break detected pulse |

## Verification
Two events can land on the same clock edge. The first is a completed transmit handshake at the same moment as a new data write. The bench raises `tx_ready` in the very cycle that carries a data write and expects the new byte to remain offered afterward, not lost. The second is a command byte that carries a reset in its misc field together with an enable in its transmit or receive field. The bench expects the enable to win, while the pending byte is still dropped or the flush strobe still fires.

// File: rtl/uart_regctl_pkg.sv
package uart_regctl_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned OFS_W  = 6;

    localparam logic [OFS_W-1:0] OFS_MODE = 6'h00;
    localparam logic [OFS_W-1:0] OFS_STAT = 6'h04;
    localparam logic [OFS_W-1:0] OFS_CMD  = 6'h08;
    localparam logic [OFS_W-1:0] OFS_DATA = 6'h0C;
    localparam logic [OFS_W-1:0] OFS_INT  = 6'h14;
    localparam logic [OFS_W-1:0] OFS_DIVH = 6'h18;
    localparam logic [OFS_W-1:0] OFS_DIVL = 6'h1C;

    // mode register 1 bit choosing the receive interrupt source
    localparam int unsigned MODE_RXSEL_BIT = 6;

    typedef enum logic [2:0] {
        MISC_NOP       = 3'd0,
        MISC_PTR_RST   = 3'd1,
        MISC_RX_RST    = 3'd2,
        MISC_TX_RST    = 3'd3,
        MISC_ERR_RST   = 3'd4,
        MISC_BRK_CLR   = 3'd5,
        MISC_BRK_START = 3'd6,
        MISC_BRK_STOP  = 3'd7
    } misc_cmd_e;

    typedef enum logic [1:0] {
        DIR_KEEP = 2'd0,
        DIR_ON   = 2'd1,
        DIR_OFF  = 2'd2,
        DIR_RSVD = 2'd3
    } dir_cmd_e;

    typedef struct packed {
        logic ptr_rst;
        logic rx_rst;
        logic tx_rst;
        logic brk_clr;
        logic tx_on;
        logic tx_off;
        logic rx_on;
        logic rx_off;
    } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
    import uart_regctl_pkg::*;
(
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_byte,
    output cmd_act_t          act
);
    misc_cmd_e misc;
    dir_cmd_e  txf;
    dir_cmd_e  rxf;

    always_comb begin
        misc = misc_cmd_e'(cmd_byte[6:4]);
        txf  = dir_cmd_e'(cmd_byte[3:2]);
        rxf  = dir_cmd_e'(cmd_byte[1:0]);
        act  = '0;
        if (cmd_we) begin
            unique case (misc)
                MISC_PTR_RST: act.ptr_rst = 1'b1;
                MISC_RX_RST:  act.rx_rst  = 1'b1;
                MISC_TX_RST:  act.tx_rst  = 1'b1;
                MISC_BRK_CLR: act.brk_clr = 1'b1;
                default:      ;
            endcase
            act.tx_on  = (txf == DIR_ON);
            act.tx_off = (txf == DIR_OFF);
            act.rx_on  = (rxf == DIR_ON);
            act.rx_off = (rxf == DIR_OFF);
        end
    end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_regctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              rst_cmd,
    input  logic              on_cmd,
    input  logic              off_cmd,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_en,
    output logic              tx_empty
);
    typedef struct packed {
        logic              en;
        logic              pend;
        logic [BYTE_W-1:0] data;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.en && st_q.pend && tx_ready) st_d.pend = 1'b0;
        // order of fields: reset first, then enable/disable
        if (rst_cmd) begin
            st_d.en   = 1'b0;
            st_d.pend = 1'b0;
        end
        if (on_cmd)  st_d.en = 1'b1;
        if (off_cmd) st_d.en = 1'b0;
        if (wr_en) begin
            st_d.pend = 1'b1;
            st_d.data = wr_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_valid = st_q.en & st_q.pend;
    assign tx_data  = st_q.data;
    assign tx_en    = st_q.en;
    assign tx_empty = ~st_q.pend;
endmodule

// File: rtl/uart_irq_ctl.sv
module uart_irq_ctl
    import uart_regctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [BYTE_W-1:0] mask_byte,
    input  logic              brk_set,
    input  logic              brk_clr,
    input  logic              tx_src,
    input  logic              rx_src,
    output logic [BYTE_W-1:0] isr,
    output logic              irq
);
    typedef struct packed {
        logic [BYTE_W-1:0] imr;
        logic              dbrk;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.imr = mask_byte;
        if (brk_clr) st_d.dbrk = 1'b0;
        if (brk_set) st_d.dbrk = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        isr    = '0;
        isr[0] = tx_src;
        isr[1] = rx_src;
        isr[2] = st_q.dbrk;
        irq    = |(isr & st_q.imr);
    end
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import uart_regctl_pkg::*;
#(
    parameter logic [7:0] DIV_HI_INIT = 8'h00,
    parameter logic [7:0] DIV_LO_INIT = 8'h1A,
    parameter int unsigned MODE_REGS  = 2
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req,
    input  logic       bus_we,
    input  logic [5:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    output logic       tx_valid,
    input  logic       tx_ready,
    output logic [7:0] tx_data,
    input  logic [7:0] rx_head,
    input  logic       rx_empty,
    input  logic       rx_full,
    output logic       rx_pop,
    output logic       rx_flush,
    output logic       rx_enable,
    input  logic       brk_evt
);
    localparam int unsigned PTR_W = (MODE_REGS > 1) ? $clog2(MODE_REGS) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MODE_REGS - 1);

    typedef struct packed {
        logic [MODE_REGS-1:0][BYTE_W-1:0] mr;
        logic [PTR_W-1:0]                 ptr;
        logic                             rx_en;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              wr_mode, wr_cmd, wr_data, wr_mask, rd_data;
    cmd_act_t          act;
    logic              tx_en, tx_empty;
    logic [BYTE_W-1:0] isr, status;
    logic              rx_src;
    logic [PTR_W-1:0]  mode_ptr;

    assign wr_mode = bus_req &  bus_we & (bus_addr == OFS_MODE);
    assign wr_cmd  = bus_req &  bus_we & (bus_addr == OFS_CMD);
    assign wr_data = bus_req &  bus_we & (bus_addr == OFS_DATA);
    assign wr_mask = bus_req &  bus_we & (bus_addr == OFS_INT);
    assign rd_data = bus_req & ~bus_we & (bus_addr == OFS_DATA);

    uart_cmd_decode u_dec (
        .cmd_we   (wr_cmd),
        .cmd_byte (bus_wdata),
        .act      (act)
    );

    uart_tx_hold u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_data),
        .wr_byte  (bus_wdata),
        .rst_cmd  (act.tx_rst),
        .on_cmd   (act.tx_on),
        .off_cmd  (act.tx_off),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_en    (tx_en),
        .tx_empty (tx_empty)
    );

    assign rx_src = st_q.mr[0][MODE_RXSEL_BIT] ? rx_full : ~rx_empty;

    uart_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (wr_mask),
        .mask_byte (bus_wdata),
        .brk_set   (brk_evt),
        .brk_clr   (act.brk_clr),
        .tx_src    (tx_en),
        .rx_src    (rx_src),
        .isr       (isr),
        .irq       (irq)
    );

    always_comb begin
        st_d = st_q;
        if (wr_mode) begin
            st_d.mr[st_q.ptr] = bus_wdata;
            st_d.ptr          = PTR_LAST;
        end
        if (act.ptr_rst) st_d.ptr   = '0;
        if (act.rx_rst)  st_d.rx_en = 1'b0;
        if (act.rx_on)   st_d.rx_en = 1'b1;
        if (act.rx_off)  st_d.rx_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_ptr = st_q.ptr;
    assign status   = {4'b0000, tx_empty, tx_en, rx_full, ~rx_empty};

    always_comb begin
        bus_rdata = '0;
        if (bus_req && !bus_we) begin
            unique case (bus_addr)
                OFS_MODE: bus_rdata = st_q.mr[mode_ptr];
                OFS_STAT: bus_rdata = status;
                OFS_DATA: bus_rdata = rx_empty ? '0 : rx_head;
                OFS_INT:  bus_rdata = isr;
                OFS_DIVH: bus_rdata = DIV_HI_INIT;
                OFS_DIVL: bus_rdata = DIV_LO_INIT;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign rx_pop    = rd_data & ~rx_empty;
    assign rx_flush  = act.rx_rst;
    assign rx_enable = st_q.rx_en;
endmodule

// File: rtl/uart_regctl_chk.sv
module uart_regctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_we,
    input logic [5:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_data,
    input logic       rx_empty,
    input logic       rx_pop,
    input logic       rx_enable,
    input logic       mode_ptr
);
    // R8: a stalled offer keeps its byte until a write intervenes
    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready && !(bus_req && bus_we) |=> tx_valid && $stable(tx_data));

    // R11: pop only during a data read of a non-empty FIFO
    assert_pop_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> bus_req && !bus_we && bus_addr == 6'h0C && !rx_empty);

    // R3: a mode write leaves the pointer on the second register
    assert_ptr_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == 6'h00 |=> mode_ptr);

    // R7: transmitter reset without enable silences the handoff
    assert_txrst_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == 6'h08 && bus_wdata[6:4] == 3'd3
        && bus_wdata[3:2] != 2'd1 |=> !tx_valid);

    // R6: receiver reset without enable leaves the receiver off
    assert_rxrst_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_we && bus_addr == 6'h08 && bus_wdata[6:4] == 3'd2
        && bus_wdata[1:0] != 2'd1 |=> !rx_enable);
endmodule

bind uart_regctl uart_regctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .rx_empty  (rx_empty),
    .rx_pop    (rx_pop),
    .rx_enable (rx_enable),
    .mode_ptr  (mode_ptr)
);

// File: tb/uart_regctl_tb.sv
`timescale 1ns/1ps
module uart_regctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0, bus_we = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq, tx_valid, rx_pop, rx_flush, rx_enable;
    logic       tx_ready = 1'b0;
    logic [7:0] tx_data;
    logic [7:0] rx_head = '0;
    logic       rx_empty = 1'b1, rx_full = 1'b0, brk_evt = 1'b0;

    int vectors = 0;
    int misses  = 0;
    logic last_flush;
    logic last_pop;

    always #10 clk = ~clk;

    uart_regctl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .rx_head(rx_head), .rx_empty(rx_empty), .rx_full(rx_full),
        .rx_pop(rx_pop), .rx_flush(rx_flush), .rx_enable(rx_enable),
        .brk_evt(brk_evt)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            misses++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        #2 last_flush = rx_flush;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        #2 d = bus_rdata; last_pop = rx_pop;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic t_reset();
        rd_chk("R1 status", 6'h04, 8'h08);
        rd_chk("R1 mode1", 6'h00, 8'h00);
        rd_chk("R1 isr", 6'h14, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        chk("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
        chk("R1 rx_enable", {7'd0, rx_enable}, 8'h00);
    endtask

    task automatic t_map();
        wr(6'h04, 8'hFF);
        wr(6'h10, 8'hFF);
        wr(6'h18, 8'h77);
        rd_chk("R2 status after ignored writes", 6'h04, 8'h08);
        rd_chk("R2 isr unchanged", 6'h14, 8'h00);
        rd_chk("R2 divider hi", 6'h18, 8'h00);
        rd_chk("R2 divider lo", 6'h1C, 8'h1A);
        rd_chk("R2 cmd offset reads 0", 6'h08, 8'h00);
        rd_chk("R2 unused 0x10", 6'h10, 8'h00);
        rd_chk("R2 unused 0x3C", 6'h3C, 8'h00);
        chk("R2 irq after ignored writes", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_mode();
        wr(6'h00, 8'h40);
        wr(6'h00, 8'h13);
        rd_chk("R3 second write to mode2", 6'h00, 8'h13);
        wr(6'h00, 8'h99);
        rd_chk("R3 pointer stays on mode2", 6'h00, 8'h99);
        wr(6'h08, 8'h10);
        rd_chk("R3 pointer reset to mode1", 6'h00, 8'h40);
        rd_chk("R3 read keeps pointer", 6'h00, 8'h40);
    endtask

    task automatic t_tx();
        wr(6'h0C, 8'hA5);
        rd_chk("R8 pending while disabled", 6'h04, 8'h00);
        chk("R8 no offer while disabled", {7'd0, tx_valid}, 8'h00);
        wr(6'h08, 8'h04);
        rd_chk("R4 enabled with pending", 6'h04, 8'h04);
        chk("R8 offer after enable", {7'd0, tx_valid}, 8'h01);
        chk("R8 offered byte", tx_data, 8'hA5);
        repeat (3) @(negedge clk);
        chk("R8 stall holds byte", tx_data, 8'hA5);
        wr(6'h0C, 8'h5A);
        chk("R8 overwrite while stalled", tx_data, 8'h5A);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        chk("R8 handshake clears offer", {7'd0, tx_valid}, 8'h00);
        rd_chk("R4 enabled and empty", 6'h04, 8'h0C);
        wr(6'h0C, 8'h22);
        chk("R8 new offer", tx_data, 8'h22);
        // handshake and data write on the same edge
        @(negedge clk);
        tx_ready = 1'b1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'h0C; bus_wdata = 8'h33;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; tx_ready = 1'b0;
        chk("R8 same-edge write stays pending", {7'd0, tx_valid}, 8'h01);
        chk("R8 same-edge byte", tx_data, 8'h33);
        @(negedge clk); tx_ready = 1'b1;
        @(negedge clk); tx_ready = 1'b0;
        chk("R8 drained", {7'd0, tx_valid}, 8'h00);
    endtask

    task automatic t_cmd();
        wr(6'h08, 8'h0C);
        rd_chk("R5 reserved tx field ignored", 6'h04, 8'h0C);
        wr(6'h08, 8'h03);
        chk("R5 reserved rx field ignored", {7'd0, rx_enable}, 8'h00);
        wr(6'h0C, 8'h44);
        chk("R8 pending before combo", {7'd0, tx_valid}, 8'h01);
        wr(6'h08, 8'h34);
        chk("R7 combo drops pending byte", {7'd0, tx_valid}, 8'h00);
        rd_chk("R5 enable field wins over reset", 6'h04, 8'h0C);
        wr(6'h08, 8'h30);
        rd_chk("R7 reset disables", 6'h04, 8'h08);
        wr(6'h0C, 8'h55);
        rd_chk("R7 pending while disabled", 6'h04, 8'h00);
        wr(6'h08, 8'h30);
        rd_chk("R7 reset marks empty", 6'h04, 8'h08);
        wr(6'h08, 8'h04);
        chk("R7 enable sends nothing", {7'd0, tx_valid}, 8'h00);
    endtask

    task automatic t_rx();
        wr(6'h08, 8'h01);
        chk("R5 rx enable", {7'd0, rx_enable}, 8'h01);
        wr(6'h08, 8'h21);
        chk("R6 flush on combo", {7'd0, last_flush}, 8'h01);
        chk("R5 rx enable wins over reset", {7'd0, rx_enable}, 8'h01);
        wr(6'h08, 8'h20);
        chk("R6 flush pulse", {7'd0, last_flush}, 8'h01);
        chk("R6 reset disables receiver", {7'd0, rx_enable}, 8'h00);
        wr(6'h08, 8'h01);
        chk("R6 no flush on plain enable", {7'd0, last_flush}, 8'h00);
        wr(6'h08, 8'h02);
        chk("R5 rx disable", {7'd0, rx_enable}, 8'h00);
    endtask

    task automatic t_rxread();
        rx_empty = 1'b0; rx_full = 1'b1; rx_head = 8'h7E;
        rd_chk("R4 fifo bits", 6'h04, 8'h0F);
        rd_chk("R11 head data", 6'h0C, 8'h7E);
        chk("R11 pop strobe", {7'd0, last_pop}, 8'h01);
        rx_full = 1'b0; rx_head = 8'h3C;
        rd_chk("R11 next head", 6'h0C, 8'h3C);
        rx_empty = 1'b1;
        rd_chk("R11 empty reads zero", 6'h0C, 8'h00);
        chk("R11 no pop when empty", {7'd0, last_pop}, 8'h00);
        rd_chk("R4 empty fifo bits", 6'h04, 8'h0C);
    endtask

    task automatic t_irq();
        rd_chk("R9 tx source", 6'h14, 8'h01);
        chk("R10 masked off", {7'd0, irq}, 8'h00);
        wr(6'h14, 8'h01);
        chk("R10 tx unmasked", {7'd0, irq}, 8'h01);
        wr(6'h08, 8'h08);
        rd_chk("R9 tx disabled", 6'h14, 8'h00);
        chk("R10 no source", {7'd0, irq}, 8'h00);
        rx_empty = 1'b0;
        rd_chk("R9 full-select ignores not-empty", 6'h14, 8'h00);
        rx_full = 1'b1;
        rd_chk("R9 full-select sees full", 6'h14, 8'h02);
        wr(6'h14, 8'h02);
        chk("R10 rx unmasked", {7'd0, irq}, 8'h01);
        rx_full = 1'b0;
        wr(6'h08, 8'h10);
        wr(6'h00, 8'h00);
        rd_chk("R9 ready-select sees not-empty", 6'h14, 8'h02);
        rx_empty = 1'b1;
        rd_chk("R9 ready-select empty", 6'h14, 8'h00);
        @(negedge clk); brk_evt = 1'b1;
        @(negedge clk); brk_evt = 1'b0;
        rd_chk("R9 delta-break latched", 6'h14, 8'h04);
        chk("R10 break masked", {7'd0, irq}, 8'h00);
        wr(6'h14, 8'h04);
        chk("R10 break unmasked", {7'd0, irq}, 8'h01);
        // clear and set on the same edge: set wins
        @(negedge clk);
        brk_evt = 1'b1;
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 6'h08; bus_wdata = 8'h50;
        @(negedge clk);
        brk_evt = 1'b0; bus_req = 1'b0; bus_we = 1'b0;
        rd_chk("R9 set beats clear", 6'h14, 8'h04);
        wr(6'h08, 8'h50);
        rd_chk("R9 delta-break cleared", 6'h14, 8'h00);
        chk("R10 irq low after clear", {7'd0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_mode();
        t_tx();
        t_cmd();
        t_rx();
        t_rxread();
        t_irq();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule